// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between a 32-bit instruction memory port and the decode stage of a small pipelined processor. It keeps up to 16 bytes of upcoming instruction stream, organised as eight 16-bit slots. It refills itself one aligned 32-bit word at a time, but only in cycles when the processor's data side leaves memory idle and there is room for the word. Decode takes instructions that are either one halfword or two halfwords long. The length is read from a single opcode bit of the first halfword.

Memory answers a granted fetch exactly one cycle later, and at most one fetch is ever outstanding. When a branch is taken, the processor raises a redirect with a halfword-aligned target. The queue then drops everything it holds, ignores the response that arrives in that cycle, and restarts fetching at the word that contains the target. If the target is the upper half of that word, the lower halfword of the first returned word is thrown away.

Top module: `ifetch_queue`

## Requirements
- R1: After reset the queue is empty, `instr_valid` is 0 and `fetch_addr` is 0, so the first request reads address 0.
- R2: `fetch_req` is never high while `mem_busy` is high.
- R3: `fetch_req` is high exactly when `mem_busy` and `redirect` are low and the sum of the queued halfwords and 2 for a response still due this cycle is at most SLOTS-2. Each response arrives the cycle after its request, and the queue never holds more than SLOTS halfwords.
- R4: `fetch_addr` increases by 4 after every cycle in which `fetch_req` is high.
- R5: When bit LONG_BIT (default 15) of the head halfword is 0, the instruction is short. It is presented as soon as one halfword is queued, with `instr_long`=0 and `instr_data` = {16'h0, head halfword}.
- R6: When bit LONG_BIT of the head halfword is 1, the instruction is long. `instr_valid` is held low until two halfwords are queued, and then `instr_long`=1.
- R7: An instruction is consumed on a cycle with `instr_valid` and `instr_take` both high. A take while `instr_valid` is low has no effect.
- R8: `redirect` empties the queue by the next cycle and discards the response arriving in the same cycle. It also suppresses both fetch and take in that cycle, and the next request goes to the target rounded down to a multiple of 4.
- R9: If bit 1 of the redirect target is set, only bits 31:16 of the first accepted word after the redirect are queued.
- R10: Bits 15:0 of a fetched word precede bits 31:16 in the instruction stream. A long instruction appears as `instr_data` = {second halfword, first halfword}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_busy | input | 1 | The data side is using memory this cycle |
| fetch_req | output | 1 | Word fetch issued (granted) this cycle |
| fetch_addr | output | ADDR_W | Word-aligned fetch address |
| resp_valid | input | 1 | Fetch response present (one cycle after a request) |
| resp_data | input | 32 | Fetched word |
| redirect | input | 1 | Taken branch: flush and refetch |
| redirect_pc | input | ADDR_W | Halfword-aligned branch target |
| instr_valid | output | 1 | A complete instruction is at the head |
| instr_long | output | 1 | The head instruction is two halfwords |
| instr_data | output | 32 | Head instruction bits |
| instr_take | input | 1 | Decode consumes the head instruction |

## Verification
The bench builds the block with its defaults: SLOTS=8, LONG_BIT=15 and a 32-bit address. With only eight slots, a few dozen cycles without takes bring the queue to full. That makes the SLOTS-2 room rule and the back-to-back fetch limit easy to exercise. Because bit 15 of the generated halfword stream depends on address bits 1, 3 and 6, long instructions fall on both halves of a word and often straddle two words. Redirect targets are drawn over a 64 KB window and include both halfword alignments. They land in cycles with and without a response due, so the discard and drop-leading-half paths are both covered.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ifq_fetch.sv
// Fetch sequencer: address counter, single-outstanding tracking, room rule,
// and the drop-leading-half flag for unaligned redirect targets.
module ifq_fetch #(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 8,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_busy,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_pc,
  input  logic              resp_valid,
  input  logic [LVL_W-1:0]  level,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              accept,
  output logic              accept_one
);
  localparam int SUM_W = LVL_W + 1;

  logic [ADDR_W-1:0] addr_q;
  logic              inflight_q;
  logic              skip_q;
  logic [SUM_W-1:0]  pending;
  logic              room;

  // Halfwords that will be queued once the response due this cycle lands.
  always_comb begin
    pending = {1'b0, level} + (inflight_q ? SUM_W'(2) : SUM_W'(0));
    room    = pending <= SUM_W'(SLOTS - 2);
  end

  assign fetch_req  = !rst && !mem_busy && !redirect && room;
  assign fetch_addr = addr_q;
  assign accept     = resp_valid && inflight_q && !redirect;
  assign accept_one = skip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      inflight_q <= 1'b0;
      skip_q     <= 1'b0;
    end else begin
      inflight_q <= fetch_req;
      if (redirect) begin
        addr_q <= {redirect_pc[ADDR_W-1:2], 2'b00};
        skip_q <= redirect_pc[1];
      end else begin
        if (fetch_req) addr_q <= addr_q + ADDR_W'(4);
        if (accept)    skip_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ifq_slots.sv
// Halfword slot ring: up to two writes and two reads per cycle.
// SLOTS must be a power of two so the pointers wrap on their own.
module ifq_slots
  import ifq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int PTR_W = 3,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic             wr_one,
  input  word_t            wr_data,
  input  logic             rd_en,
  input  logic             rd_two,
  output half_t            head0,
  output half_t            head1,
  output logic [LVL_W-1:0] level
);
  half_t            mem [SLOTS];
  logic [PTR_W-1:0] wp, rp;
  logic [LVL_W-1:0] n_wr, n_rd;

  always_comb begin
    n_wr = wr_en ? (wr_one ? LVL_W'(1) : LVL_W'(2)) : LVL_W'(0);
    n_rd = rd_en ? (rd_two ? LVL_W'(2) : LVL_W'(1)) : LVL_W'(0);
  end

  assign head0 = mem[rp];
  assign head1 = mem[rp + PTR_W'(1)];

  // Storage has no reset; only the pointers and level do.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_one) begin
        mem[wp] <= wr_data[31:16];
      end else begin
        mem[wp]              <= wr_data[15:0];
        mem[wp + PTR_W'(1)]  <= wr_data[31:16];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      wp    <= wp + PTR_W'(n_wr);
      rp    <= rp + PTR_W'(n_rd);
      level <= level + n_wr - n_rd;
    end
  end
endmodule

// File: rtl/ifq_head.sv
// Head presentation: length decode and take handling.
module ifq_head
  import ifq_pkg::*;
#(
  parameter int LONG_BIT = 15,
  parameter int LVL_W    = 4
) (
  input  half_t            head0,
  input  half_t            head1,
  input  logic [LVL_W-1:0] level,
  input  logic             take,
  input  logic             flush,
  output logic             instr_valid,
  output logic             instr_long,
  output word_t            instr_data,
  output logic             rd_en,
  output logic             rd_two
);
  always_comb begin
    instr_long  = head0[LONG_BIT];
    instr_valid = (level != '0) && (!instr_long || level >= LVL_W'(2));
    instr_data  = instr_long ? {head1, head0} : {16'h0000, head0};
    rd_en       = instr_valid && take && !flush;
    rd_two      = instr_long;
  end
endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue
  import ifq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SLOTS    = 8,
  parameter int LONG_BIT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_busy,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              resp_valid,
  input  logic [31:0]       resp_data,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_pc,
  output logic              instr_valid,
  output logic              instr_long,
  output logic [31:0]       instr_data,
  input  logic              instr_take
);
  localparam int PTR_W = $clog2(SLOTS);
  localparam int LVL_W = $clog2(SLOTS + 1);

  logic             accept, accept_one, rd_en, rd_two;
  half_t            head0, head1;
  logic [LVL_W-1:0] slot_level;

  ifq_fetch #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .LVL_W(LVL_W)) u_fetch (
    .clk(clk), .rst(rst), .mem_busy(mem_busy), .redirect(redirect),
    .redirect_pc(redirect_pc), .resp_valid(resp_valid), .level(slot_level),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .accept(accept), .accept_one(accept_one)
  );

  ifq_slots #(.SLOTS(SLOTS), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_slots (
    .clk(clk), .rst(rst), .flush(redirect),
    .wr_en(accept), .wr_one(accept_one), .wr_data(resp_data),
    .rd_en(rd_en), .rd_two(rd_two),
    .head0(head0), .head1(head1), .level(slot_level)
  );

  ifq_head #(.LONG_BIT(LONG_BIT), .LVL_W(LVL_W)) u_head (
    .head0(head0), .head1(head1), .level(slot_level),
    .take(instr_take), .flush(redirect),
    .instr_valid(instr_valid), .instr_long(instr_long), .instr_data(instr_data),
    .rd_en(rd_en), .rd_two(rd_two)
  );
endmodule

// File: rtl/ifq_checker.sv
module ifq_checker #(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 8,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_busy,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              resp_valid,
  input logic              redirect,
  input logic [ADDR_W-1:0] redirect_pc,
  input logic              instr_valid,
  input logic              instr_long,
  input logic [LVL_W-1:0]  level
);
  a_r2_idle_only: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> !mem_busy);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(SLOTS));

  a_r3_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    fetch_req |=> resp_valid);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    fetch_req |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4));

  a_r6_long_complete: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_long) |-> level >= LVL_W'(2));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (level == '0) && !instr_valid);

  a_r8_target_halfword: assert property (@(posedge clk) disable iff (rst)
    redirect |-> !redirect_pc[0]);

  a_r9_word_restart: assert property (@(posedge clk) disable iff (rst)
    redirect |=> fetch_addr[1:0] == 2'b00);
endmodule

bind ifetch_queue ifq_checker #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .mem_busy(mem_busy), .fetch_req(fetch_req),
  .fetch_addr(fetch_addr), .resp_valid(resp_valid), .redirect(redirect),
  .redirect_pc(redirect_pc), .instr_valid(instr_valid), .instr_long(instr_long),
  .level(slot_level)
);

// File: tb/test_ifetch_queue.sv
`timescale 1ns/1ps
module test_ifetch_queue;
  localparam int SLOTS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_busy = 1'b0;
  logic        fetch_req;
  logic [31:0] fetch_addr;
  logic        resp_valid = 1'b0;
  logic [31:0] resp_data = '0;
  logic        redirect = 1'b0;
  logic [31:0] redirect_pc = '0;
  logic        instr_valid, instr_long;
  logic [31:0] instr_data;
  logic        instr_take = 1'b0;

  always #4 clk = ~clk;

  ifetch_queue #(.ADDR_W(32), .SLOTS(SLOTS), .LONG_BIT(15)) i_ifetch_queue (
    .clk(clk), .rst(rst), .mem_busy(mem_busy), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .resp_valid(resp_valid), .resp_data(resp_data),
    .redirect(redirect), .redirect_pc(redirect_pc), .instr_valid(instr_valid),
    .instr_long(instr_long), .instr_data(instr_data), .instr_take(instr_take)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Scoreboard entry: {long, data}
  logic [32:0] sb[$];

  // Reference model state
  int          lvl = 0;
  logic [31:0] exp_addr = '0;
  bit          skip = 1'b0;
  bit          after_redir = 1'b0;
  bit          after_unal  = 1'b0;

  function automatic logic [15:0] hw(input logic [31:0] a);
    return {a[1] ^ a[3] ^ a[6], a[15:1]};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {hw(a + 32'd2), hw(a)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [32:0] act,
                       input logic [32:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver side of the scoreboard: expected instruction stream from pc.
  task automatic push_stream(input logic [31:0] pc, input int n);
    logic [31:0] p = pc;
    for (int i = 0; i < n; i++) begin
      logic [15:0] h = hw(p);
      if (h[15]) begin
        sb.push_back({1'b1, hw(p + 32'd2), h});
        p = p + 32'd4;
      end else begin
        sb.push_back({1'b0, 16'h0000, h});
        p = p + 32'd2;
      end
    end
  endtask

  // One cycle: drive at the falling edge, sample, update model, answer memory.
  task automatic step(input bit busy, input bit take, input bit redir,
                      input logic [31:0] rpc);
    bit          exp_req, exp_valid, head_long, req_s;
    logic [31:0] addr_s;
    int          w, r;
    @(negedge clk);
    mem_busy = busy; instr_take = take; redirect = redir; redirect_pc = rpc;
    #1;
    exp_req   = !busy && !redir && (lvl + (resp_valid ? 2 : 0) <= SLOTS - 2);
    head_long = (sb.size() > 0) ? sb[0][32] : 1'b0;
    exp_valid = (lvl >= 1) && (!head_long || lvl >= 2);

    if (busy) check(fetch_req == 1'b0, "R2", {32'd0, fetch_req}, 33'd0);
    else      check(fetch_req == exp_req, "R3", {32'd0, fetch_req}, {32'd0, exp_req});

    if (after_unal)       check(fetch_addr == exp_addr, "R9", {1'b0, fetch_addr}, {1'b0, exp_addr});
    else if (after_redir) check(fetch_addr == exp_addr, "R8", {1'b0, fetch_addr}, {1'b0, exp_addr});
    else                  check(fetch_addr == exp_addr, "R4", {1'b0, fetch_addr}, {1'b0, exp_addr});

    if (after_redir)          check(instr_valid == exp_valid, "R8", {32'd0, instr_valid}, {32'd0, exp_valid});
    else if (take && !exp_valid) check(instr_valid == 1'b0, "R7", {32'd0, instr_valid}, 33'd0);
    else if (head_long)       check(instr_valid == exp_valid, "R6", {32'd0, instr_valid}, {32'd0, exp_valid});
    else                      check(instr_valid == exp_valid, "R5", {32'd0, instr_valid}, {32'd0, exp_valid});

    r = 0;
    if (exp_valid && take && !redir && sb.size() > 0) begin
      // Monitor side of the scoreboard
      logic [32:0] e = sb.pop_front();
      check(instr_long == e[32], "R6", {32'd0, instr_long}, {32'd0, e[32]});
      if (e[32]) check(instr_data == e[31:0], "R10", {1'b0, instr_data}, e);
      else       check(instr_data == e[31:0], "R5", {1'b0, instr_data}, e);
      r = e[32] ? 2 : 1;
    end

    w = 0;
    if (resp_valid && !redir) begin
      w = skip ? 1 : 2;
      skip = 1'b0;
    end
    after_redir = redir;
    after_unal  = redir && rpc[1];
    if (redir) begin
      lvl = 0;
      exp_addr = {rpc[31:2], 2'b00};
      skip = rpc[1];
      sb.delete();
      push_stream(rpc, 400);
    end else begin
      lvl = lvl + w - r;
      if (exp_req) exp_addr = exp_addr + 32'd4;
    end
    req_s = fetch_req; addr_s = fetch_addr;
    @(posedge clk); #1;
    resp_valid = req_s;
    resp_data  = mem_word(addr_s);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    push_stream(32'h0, 2000);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    @(negedge clk); #1;
    check(instr_valid == 1'b0, "R1", {32'd0, instr_valid}, 33'd0);
    check(fetch_addr == 32'd0, "R1", {1'b0, fetch_addr}, 33'd0);
    check(fetch_req == 1'b1, "R1", {32'd0, fetch_req}, 33'd1);
    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;

    // Free-running: memory always idle, decode always taking
    for (int i = 0; i < 200; i++) step(1'b0, 1'b1, 1'b0, '0);
    // Random memory contention and stalls
    for (int i = 0; i < 600; i++) step(($urandom % 3) == 0, ($urandom % 4) != 0, 1'b0, '0);
    // Decode stalled: queue fills, fetching must stop (R3)
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'b0, '0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0, '0);
    // Redirects: aligned and unaligned, under varying load (R8, R9)
    for (int k = 0; k < 30; k++) begin
      logic [31:0] tgt = $urandom & 32'h0000_fffe;
      if (k % 3 == 0) tgt[1] = 1'b1;
      if (k % 3 == 1) tgt[1] = 1'b0;
      step(($urandom % 4) == 0, 1'b1, 1'b1, tgt);
      if (k % 5 == 0) step(1'b0, 1'b1, 1'b1, tgt + 32'd6);
      for (int i = 0; i < 30 + (k % 7) * 5; i++)
        step(($urandom % 3) == 0, ($urandom % 3) != 0, 1'b0, '0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule